// File: doc/BRIEF.md
# Four-Wide Register Rename Unit

This block renames a group of up to four instructions in a single cycle. Each instruction lane brings two source architectural register numbers and one destination architectural register number. Every real destination receives a fresh physical register taken from a free pool. Destination reuse and reads ahead of writes therefore stop being hazards further down the pipeline. A speculative map table turns sources into physical tags. Matching inside the group ensures that a later lane sees the mapping that an earlier lane of the same group has just created.

Renaming outputs are combinational from the current state and the group inputs. They are valid in the cycle where `grpValid` and `ready` are both high, and the state updates at the following clock edge. At commit, retiring instructions return their superseded physical register to the pool and update a committed map. A flush copies the committed map into the speculative map. It also returns every register allocated since the last commit to the pool, in allocation order.

Top module: `rename_unit`

## Requirements
- R1: When `grpValid` and `ready` are both high, each lane that has a destination receives a new tag. Tags are taken from the head of the free list in FIFO order, and lanes are served in ascending index order.
- R2: A source reads the speculative map. If an earlier valid lane of the same group writes that architectural register, the source instead takes the new tag of the latest such earlier lane.
- R3: `oldTag` of a lane is the mapping its destination had just before that lane. This includes a mapping made by an earlier lane of the same group.
- R4: Architectural register 31 is the zero register. As a source it gives its zero flag = 1 and tag 0. As a destination it gives `hasDst` = 0 and `newTag` = `oldTag` = 0, and it consumes no physical register.
- R5: If fewer registers are free than the group has destinations, `ready` is 0. The group is then not renamed at all, and neither map nor free list changes.
- R6: For each retiring lane whose architectural register is not 31, `retOldTag` is appended to the tail of the free list. Lanes are appended in ascending index order. The register can be allocated from the next cycle on.
- R7: Retirement writes `retNewTag` into the committed map. While `flush` is high, `ready` is 0. One cycle later the speculative map equals the committed map, and all registers allocated since the last commit are back at the front of the free list in their original order.
- R8: After reset, architectural register i maps to physical register i for i < 31. The free list holds physical registers 31 to 63 in ascending order.
- R9: A lane with `laneValid` = 0 has no destination. It allocates nothing, changes no mapping, and is never a match source for later lanes.
- R10: If several lanes of one group write the same architectural register, the highest-index lane defines the mapping seen by later groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Restore speculative state from committed state |
| grpValid | input | 1 | A rename group is presented |
| laneValid | input | 4 | Per-lane instruction valid |
| srcA | input | 4x5 | First source architectural register per lane |
| srcB | input | 4x5 | Second source architectural register per lane |
| dst | input | 4x5 | Destination architectural register per lane (31 = none) |
| ready | output | 1 | Group can be renamed this cycle |
| srcATag | output | 4x6 | Physical tag of first source |
| srcBTag | output | 4x6 | Physical tag of second source |
| srcAZero | output | 4 | First source is the zero register |
| srcBZero | output | 4 | Second source is the zero register |
| hasDst | output | 4 | Lane allocates a destination |
| newTag | output | 4x6 | Newly allocated physical destination |
| oldTag | output | 4x6 | Previous physical mapping of the destination |
| retValid | input | 4 | Per-lane retire valid |
| retArch | input | 4x5 | Architectural destination of the retiring instruction |
| retNewTag | input | 4x6 | Physical tag that becomes committed |
| retOldTag | input | 4x6 | Physical tag released to the free list |

## Verification
A corrupted map entry shows up as a wrong source or old tag the first time a later group names that architectural register. A misplaced free-list pointer shows up as a repeated or out-of-order new tag, or as `ready` changing at the wrong free-register count, on the very next renaming group. Flush faults appear one cycle after the flush: sources read a stale mapping, or the reclaimed registers are handed out in the wrong order. The bench therefore follows every state-changing cycle with a group that reads back the affected mappings or draws from the free list.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int LANES     = 4;
  localparam int ARCH_REGS = 32;
  localparam int PHYS_REGS = 64;
  localparam int AW        = $clog2(ARCH_REGS);
  localparam int TW        = $clog2(PHYS_REGS);
  localparam int PW        = TW + 1;
  localparam int ZERO_REG  = ARCH_REGS - 1;
  localparam int FREE_INIT = PHYS_REGS - (ARCH_REGS - 1);

  typedef struct packed {
    logic          fire;
    logic          flush;
    logic [PW-1:0] allocCnt;
    logic [PW-1:0] retCnt;
  } ren_strobe_t;
endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        grpValid,
  input  logic [LANES-1:0]            laneValid,
  input  logic [LANES-1:0][AW-1:0]    dst,
  input  logic [LANES-1:0]            retValid,
  input  logic [LANES-1:0][AW-1:0]    retArch,
  input  logic [PW-1:0]               freeCount,
  output logic [LANES-1:0]            needMask,
  output logic [LANES-1:0][PW-1:0]    allocOff,
  output logic [LANES-1:0]            retMask,
  output logic [LANES-1:0][PW-1:0]    retOff,
  output logic                        ready,
  output ren_strobe_t                 strobe
);
  logic [PW-1:0] needAcc;
  logic [PW-1:0] retAcc;

  always_comb begin
    needAcc = '0;
    retAcc  = '0;
    for (int k = 0; k < LANES; k++) begin
      needMask[k] = laneValid[k] && (dst[k] != AW'(ZERO_REG));
      allocOff[k] = needAcc;
      needAcc     = needAcc + PW'(needMask[k]);
      retMask[k]  = retValid[k] && (retArch[k] != AW'(ZERO_REG));
      retOff[k]   = retAcc;
      retAcc      = retAcc + PW'(retMask[k]);
    end
  end

  assign ready           = !flush && (freeCount >= needAcc);
  assign strobe.fire     = grpValid && ready;
  assign strobe.flush    = flush;
  assign strobe.allocCnt = needAcc;
  assign strobe.retCnt   = retAcc;

  // R5
  ctl_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fire |-> (freeCount >= strobe.allocCnt));

  // R7
  ctl_flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !strobe.fire);
endmodule

// File: rtl/rename_freelist.sv
module rename_freelist
  import rename_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  ren_strobe_t                 strobe,
  input  logic [LANES-1:0][PW-1:0]    allocOff,
  input  logic [LANES-1:0]            retMask,
  input  logic [LANES-1:0][PW-1:0]    retOff,
  input  logic [LANES-1:0][TW-1:0]    retOldTag,
  output logic [LANES-1:0][TW-1:0]    allocTag,
  output logic [PW-1:0]               freeCount
);
  localparam int PW1 = PW + 1;

  logic [PHYS_REGS-1:0][TW-1:0] freeMem;
  logic [PW-1:0] head;
  logic [PW-1:0] tail;
  logic [PW-1:0] cmtHead;
  logic [LANES-1:0][PW-1:0] rdPtr;
  logic [LANES-1:0][PW-1:0] wrPtr;

  assign freeCount = tail - head;

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      rdPtr[k]    = head + allocOff[k];
      wrPtr[k]    = tail + retOff[k];
      allocTag[k] = freeMem[rdPtr[k][TW-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS_REGS; i++)
        freeMem[i] <= (i < FREE_INIT) ? TW'(ZERO_REG + i) : '0;
      head    <= '0;
      tail    <= PW'(FREE_INIT);
      cmtHead <= '0;
    end else begin
      for (int k = 0; k < LANES; k++)
        if (retMask[k]) freeMem[wrPtr[k][TW-1:0]] <= retOldTag[k];
      tail    <= tail + strobe.retCnt;
      cmtHead <= cmtHead + strobe.retCnt;
      if (strobe.flush)     head <= cmtHead + strobe.retCnt;
      else if (strobe.fire) head <= head + strobe.allocCnt;
    end
  end

  // R6
  fl_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (PW1'(freeCount) + PW1'(strobe.retCnt)) <= PW1'(PHYS_REGS));

  // R5
  fl_head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.fire && !strobe.flush) |=> $stable(head));
endmodule

// File: rtl/rename_maps.sv
module rename_maps
  import rename_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  ren_strobe_t                 strobe,
  input  logic [LANES-1:0]            needMask,
  input  logic [LANES-1:0][AW-1:0]    srcA,
  input  logic [LANES-1:0][AW-1:0]    srcB,
  input  logic [LANES-1:0][AW-1:0]    dst,
  input  logic [LANES-1:0][TW-1:0]    allocTag,
  input  logic [LANES-1:0]            retMask,
  input  logic [LANES-1:0][AW-1:0]    retArch,
  input  logic [LANES-1:0][TW-1:0]    retNewTag,
  output logic [LANES-1:0][TW-1:0]    srcATag,
  output logic [LANES-1:0][TW-1:0]    srcBTag,
  output logic [LANES-1:0]            srcAZero,
  output logic [LANES-1:0]            srcBZero,
  output logic [LANES-1:0][TW-1:0]    newTag,
  output logic [LANES-1:0][TW-1:0]    oldTag
);
  logic [ARCH_REGS-1:0][TW-1:0] specMap;
  logic [ARCH_REGS-1:0][TW-1:0] cmtMap;
  logic [ARCH_REGS-1:0][TW-1:0] cmtMapNext;

  function automatic logic [TW-1:0] lookup(
    input logic [AW-1:0]                  arch,
    input int                             lane,
    input logic [ARCH_REGS-1:0][TW-1:0]   mapIn,
    input logic [LANES-1:0]               need,
    input logic [LANES-1:0][AW-1:0]       dstIn,
    input logic [LANES-1:0][TW-1:0]       tagIn);
    logic [TW-1:0] t;
    t = mapIn[arch];
    for (int j = 0; j < LANES; j++)
      if (j < lane && need[j] && dstIn[j] == arch) t = tagIn[j];
    return t;
  endfunction

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      srcAZero[k] = (srcA[k] == AW'(ZERO_REG));
      srcBZero[k] = (srcB[k] == AW'(ZERO_REG));
      srcATag[k]  = srcAZero[k] ? '0 : lookup(srcA[k], k, specMap, needMask, dst, allocTag);
      srcBTag[k]  = srcBZero[k] ? '0 : lookup(srcB[k], k, specMap, needMask, dst, allocTag);
      newTag[k]   = needMask[k] ? allocTag[k] : '0;
      oldTag[k]   = needMask[k] ? lookup(dst[k], k, specMap, needMask, dst, allocTag) : '0;
    end
  end

  always_comb begin
    cmtMapNext = cmtMap;
    for (int k = 0; k < LANES; k++)
      if (retMask[k]) cmtMapNext[retArch[k]] = retNewTag[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) begin
        specMap[i] <= (i < ZERO_REG) ? TW'(i) : '0;
        cmtMap[i]  <= (i < ZERO_REG) ? TW'(i) : '0;
      end
    end else begin
      cmtMap <= cmtMapNext;
      if (strobe.flush) begin
        specMap <= cmtMapNext;
      end else if (strobe.fire) begin
        for (int k = 0; k < LANES; k++)
          if (needMask[k]) specMap[dst[k]] <= allocTag[k];
      end
    end
  end

  // R1
  for (genvar j = 0; j < LANES; j++) begin : g_pairA
    for (genvar k = j + 1; k < LANES; k++) begin : g_pairB
      map_tag_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe.fire && needMask[j] && needMask[k]) |-> (allocTag[j] != allocTag[k]));
    end
  end

  // R7
  map_flush_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.flush && (retMask == '0)) |=> (specMap == cmtMap));
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rename_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        grpValid,
  input  logic [LANES-1:0]            laneValid,
  input  logic [LANES-1:0][AW-1:0]    srcA,
  input  logic [LANES-1:0][AW-1:0]    srcB,
  input  logic [LANES-1:0][AW-1:0]    dst,
  output logic                        ready,
  output logic [LANES-1:0][TW-1:0]    srcATag,
  output logic [LANES-1:0][TW-1:0]    srcBTag,
  output logic [LANES-1:0]            srcAZero,
  output logic [LANES-1:0]            srcBZero,
  output logic [LANES-1:0]            hasDst,
  output logic [LANES-1:0][TW-1:0]    newTag,
  output logic [LANES-1:0][TW-1:0]    oldTag,
  input  logic [LANES-1:0]            retValid,
  input  logic [LANES-1:0][AW-1:0]    retArch,
  input  logic [LANES-1:0][TW-1:0]    retNewTag,
  input  logic [LANES-1:0][TW-1:0]    retOldTag
);
  ren_strobe_t              strobe;
  logic [LANES-1:0]         needMask;
  logic [LANES-1:0][PW-1:0] allocOff;
  logic [LANES-1:0]         retMask;
  logic [LANES-1:0][PW-1:0] retOff;
  logic [LANES-1:0][TW-1:0] allocTag;
  logic [PW-1:0]            freeCount;

  assign hasDst = needMask;

  rename_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .grpValid(grpValid),
    .laneValid(laneValid), .dst(dst), .retValid(retValid), .retArch(retArch),
    .freeCount(freeCount), .needMask(needMask), .allocOff(allocOff),
    .retMask(retMask), .retOff(retOff), .ready(ready), .strobe(strobe)
  );

  rename_freelist u_free (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .allocOff(allocOff),
    .retMask(retMask), .retOff(retOff), .retOldTag(retOldTag),
    .allocTag(allocTag), .freeCount(freeCount)
  );

  rename_maps u_maps (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .needMask(needMask),
    .srcA(srcA), .srcB(srcB), .dst(dst), .allocTag(allocTag),
    .retMask(retMask), .retArch(retArch), .retNewTag(retNewTag),
    .srcATag(srcATag), .srcBTag(srcBTag), .srcAZero(srcAZero),
    .srcBZero(srcBZero), .newTag(newTag), .oldTag(oldTag)
  );
endmodule

// File: tb/sim_rename_unit.sv
module sim_rename_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic grpValid = 1'b0;
  logic [3:0] laneValid = '0;
  logic [3:0][4:0] srcA = '0, srcB = '0, dst = '0;
  logic ready;
  logic [3:0][5:0] srcATag, srcBTag, newTag, oldTag;
  logic [3:0] srcAZero, srcBZero, hasDst;
  logic [3:0] retValid = '0;
  logic [3:0][4:0] retArch = '0;
  logic [3:0][5:0] retNewTag = '0, retOldTag = '0;

  always #10 clk = ~clk;

  rename_unit u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .grpValid(grpValid),
    .laneValid(laneValid), .srcA(srcA), .srcB(srcB), .dst(dst),
    .ready(ready), .srcATag(srcATag), .srcBTag(srcBTag),
    .srcAZero(srcAZero), .srcBZero(srcBZero), .hasDst(hasDst),
    .newTag(newTag), .oldTag(oldTag), .retValid(retValid),
    .retArch(retArch), .retNewTag(retNewTag), .retOldTag(retOldTag)
  );

  typedef struct {
    logic rdy;
    logic chkTags;
    logic [3:0][5:0] a, b, n, o;
    logic [3:0] za, zb, hd;
    string req;
  } exp_t;
  typedef struct { int arch; int nw; int old; } rob_t;

  exp_t expQ[$];
  rob_t rob[$];
  int freeQ[$];
  int pend[$];
  int specM[32];
  int comM[32];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic cmp(input string req, input string what, input logic [31:0] got, input logic [31:0] want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, want);
    end
  endtask

  // monitor: pops expected items and compares mid-cycle
  always begin
    @(negedge clk);
    #5;
    while (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      cmp(e.req, "ready", 32'(ready), 32'(e.rdy));
      if (e.chkTags) begin
        cmp(e.req, "srcATag", 32'(srcATag), 32'(e.a));
        cmp(e.req, "srcBTag", 32'(srcBTag), 32'(e.b));
        cmp(e.req, "newTag", 32'(newTag), 32'(e.n));
        cmp(e.req, "oldTag", 32'(oldTag), 32'(e.o));
        cmp(e.req, "srcAZero", 32'(srcAZero), 32'(e.za));
        cmp(e.req, "srcBZero", 32'(srcBZero), 32'(e.zb));
        cmp(e.req, "hasDst", 32'(hasDst), 32'(e.hd));
      end
    end
  end

  // driver: presents a group and pushes the model's expectation
  task automatic ren(input logic [3:0] lv, input logic [3:0][4:0] sa, input logic [3:0][4:0] sb,
                     input logic [3:0][4:0] d, input string req, input logic fl = 1'b0);
    exp_t e;
    int tmp[32];
    int need;
    int off;
    @(negedge clk);
    grpValid = 1'b1; laneValid = lv; srcA = sa; srcB = sb; dst = d;
    flush = fl; retValid = '0;
    need = 0;
    for (int k = 0; k < 4; k++) if (lv[k] && d[k] != 5'd31) need++;
    tmp = specM;
    off = 0;
    e.req = req;
    e.rdy = !fl && (freeQ.size() >= need);
    e.chkTags = e.rdy;
    for (int k = 0; k < 4; k++) begin
      e.za[k] = (sa[k] == 5'd31);
      e.zb[k] = (sb[k] == 5'd31);
      e.a[k] = e.za[k] ? 6'd0 : 6'(tmp[sa[k]]);
      e.b[k] = e.zb[k] ? 6'd0 : 6'(tmp[sb[k]]);
      e.hd[k] = lv[k] && d[k] != 5'd31;
      if (e.hd[k]) begin
        e.o[k] = 6'(tmp[d[k]]);
        e.n[k] = (off < freeQ.size()) ? 6'(freeQ[off]) : 6'd0;
        tmp[d[k]] = int'(e.n[k]);
        off++;
      end else begin
        e.o[k] = 6'd0;
        e.n[k] = 6'd0;
      end
    end
    expQ.push_back(e);
    if (e.rdy) begin
      specM = tmp;
      for (int k = 0; k < 4; k++)
        if (e.hd[k]) begin
          rob_t r;
          r.arch = int'(d[k]); r.nw = int'(e.n[k]); r.old = int'(e.o[k]);
          rob.push_back(r);
          pend.push_back(int'(e.n[k]));
          void'(freeQ.pop_front());
        end
    end
    if (fl) begin
      specM = comM;
      freeQ = {pend, freeQ};
      pend.delete();
      rob.delete();
    end
  endtask

  task automatic retire(input int n);
    @(negedge clk);
    grpValid = 1'b0; flush = 1'b0; laneValid = '0;
    retValid = '0;
    for (int k = 0; k < 4; k++) begin
      if (k < n && rob.size() > 0) begin
        rob_t r;
        r = rob.pop_front();
        retValid[k] = 1'b1;
        retArch[k] = 5'(r.arch);
        retNewTag[k] = 6'(r.nw);
        retOldTag[k] = 6'(r.old);
        comM[r.arch] = r.nw;
        freeQ.push_back(r.old);
        void'(pend.pop_front());
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    grpValid = 1'b0; flush = 1'b0; laneValid = '0; retValid = '0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      specM[i] = (i < 31) ? i : 0;
      comM[i] = specM[i];
    end
    for (int i = 31; i < 64; i++) freeQ.push_back(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset mapping; R4 zero register as source and as destination
    ren(4'hF, {5'd3,5'd2,5'd1,5'd0}, {5'd7,5'd6,5'd5,5'd31}, {5'd31,5'd31,5'd31,5'd31}, "R8");
    // R2 R3 R1 in-group matching on the four-instruction example
    ren(4'hF, {5'd0,5'd2,5'd4,5'd0}, {5'd0,5'd2,5'd4,5'd1}, {5'd2,5'd3,5'd1,5'd2}, "R2");
    // R10 final mapping taken from the highest lane
    ren(4'hF, {5'd1,5'd2,5'd3,5'd31}, {5'd0,5'd4,5'd31,5'd2}, {5'd31,5'd31,5'd31,5'd31}, "R10");
    // R9 invalid lanes neither allocate nor act as match sources
    ren(4'b0101, {5'd6,5'd5,5'd0,5'd1}, {5'd7,5'd6,5'd6,5'd2}, {5'd7,5'd6,5'd6,5'd5}, "R9");
    ren(4'hF, {5'd5,5'd6,5'd7,5'd6}, {5'd31,5'd7,5'd5,5'd5}, {5'd31,5'd31,5'd31,5'd31}, "R9");
    ren(4'h0, {5'd1,5'd2,5'd3,5'd4}, {5'd1,5'd2,5'd3,5'd4}, {5'd8,5'd9,5'd10,5'd11}, "R9");
    // R1 drain the pool
    while (freeQ.size() >= 4)
      ren(4'hF, {5'd11,5'd10,5'd9,5'd8}, {5'd1,5'd0,5'd11,5'd3}, {5'd8,5'd11,5'd10,5'd9}, "R1");
    // R5 all-or-nothing stall, then state unchanged
    ren(4'hF, {5'd0,5'd0,5'd0,5'd0}, {5'd0,5'd0,5'd0,5'd0}, {5'd12,5'd13,5'd14,5'd15}, "R5");
    ren(4'hF, {5'd12,5'd13,5'd14,5'd15}, {5'd8,5'd9,5'd10,5'd11}, {5'd31,5'd31,5'd31,5'd31}, "R5");
    ren(4'b0111, {5'd0,5'd12,5'd13,5'd14}, {5'd0,5'd1,5'd2,5'd3}, {5'd9,5'd13,5'd12,5'd14}, "R5");
    ren(4'h1, {5'd0,5'd0,5'd0,5'd20}, {5'd0,5'd0,5'd0,5'd21}, {5'd31,5'd31,5'd31,5'd20}, "R5");
    ren(4'hF, {5'd12,5'd13,5'd14,5'd20}, {5'd9,5'd31,5'd1,5'd2}, {5'd31,5'd31,5'd31,5'd31}, "R4");
    // R6 released registers usable on the next cycle, in release order
    retire(4);
    retire(4);
    ren(4'hF, {5'd2,5'd8,5'd9,5'd10}, {5'd3,5'd4,5'd5,5'd6}, {5'd16,5'd17,5'd18,5'd16}, "R6");
    ren(4'hF, {5'd16,5'd17,5'd18,5'd20}, {5'd0,5'd1,5'd2,5'd3}, {5'd20,5'd21,5'd31,5'd31}, "R6");
    // R7 flush restores committed map and reclaims uncommitted registers
    retire(3);
    ren(4'hF, {5'd0,5'd1,5'd2,5'd3}, {5'd4,5'd5,5'd6,5'd7}, {5'd22,5'd23,5'd24,5'd25}, "R7", 1'b1);
    ren(4'hF, {5'd2,5'd3,5'd8,5'd16}, {5'd9,5'd10,5'd20,5'd1}, {5'd31,5'd31,5'd31,5'd31}, "R7");
    ren(4'hF, {5'd16,5'd8,5'd2,5'd3}, {5'd0,5'd1,5'd4,5'd5}, {5'd26,5'd27,5'd28,5'd29}, "R7");
    retire(4);
    ren(4'hF, {5'd29,5'd28,5'd27,5'd26}, {5'd9,5'd8,5'd31,5'd3}, {5'd30,5'd0,5'd31,5'd1}, "R6");
    idle();
    idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule